// File: doc/BRIEF.md
# Upset-Correcting Serial Key Detector

This block watches a serial bit stream and raises a one-cycle match pulse each time the most recent `KEY_W` accepted bits equal the key parameter `KEY`. Matches may overlap. The detector has one state per matched-prefix length, so a 16-bit key needs 16 states. The next state comes from a transition table that is built at elaboration from the key's self-overlap structure. Encodings are assigned by hand and do not depend on any tool recoding the state machine.

The state index is never stored in plain binary. It is held as an 8-bit single-error-correcting, double-error-detecting codeword, and any two legal words differ in at least four bits. On every cycle the stored word is decoded. A single flipped bit is corrected before the index reaches the transition and match logic, so it has no effect on behaviour. The freshly encoded next state is then written back, which removes the flip. When two bits have flipped, the block drops to the idle state. Either kind of upset raises an `upset_o` pulse. A test input `seu_flip` models upsets by XOR-ing a mask into the word as it is stored.

Bits enter through a valid/ready port. `in_ready` is always high, so the block never applies back-pressure. A bit is consumed on every clock edge at which `in_valid` is high. `match_o`, `upset_o` and `seu_flip` are plain control and status pins with no handshake.

Top module: `upset_tolerant_key_fsm`

## Requirements
- R1: After reset, `match_o` and `upset_o` are low and the detector is idle, so a full key sent straight after reset is matched. `in_ready` is high in every cycle.
- R2: A bit is accepted at a rising edge where `in_valid` is high. The earliest of the last `KEY_W` accepted bits is compared with `KEY[KEY_W-1]`. When the bit that completes the key is accepted at edge k, `match_o` is high from edge k until edge k+1.
- R3: Overlapping matches are reported. With `KEY = 16'hB5B5`, sending the key followed by its low 8 bits gives a second match.
- R4: While `in_valid` is low, no bit is consumed, the matched prefix is kept, and `match_o` stays low.
- R5: The stored 8-bit state word is always a legal codeword unless a flip has just been injected. Index bits 0..3 sit at word bits 3, 5, 6 and 7. Check bits sit at word bits 1, 2 and 4, and word bit 0 is the even parity of bits 7..1.
- R6: Flipping any one of the 8 stored bits does not change the sequence of `match_o` values.
- R7: A nonzero `seu_flip` mask that lands at edge k makes `upset_o` high from edge k+1 until edge k+2. With no flip, `upset_o` stays low.
- R8: A corrupted word is rewritten clean at the next edge. This means single flips at consecutive edges, in different bits, are each corrected.
- R9: A two-bit flip that lands at edge k sends the detector to idle at edge k+1. Any bit offered in that cycle is discarded and `match_o` stays low.
- R10: `seu_flip` is ignored while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Serial bit on `in_bit` is valid |
| in_ready | output | 1 | Always high; the block never stalls the stream |
| in_bit | input | 1 | Serial data bit |
| seu_flip | input | 8 | Upset injection mask XOR-ed into the stored state word |
| match_o | output | 1 | One-cycle pulse on a key match |
| upset_o | output | 1 | One-cycle pulse when a corrupted state word was seen |

## Verification
The bench builds the block with `KEY_W = 16` and `KEY = 16'hB5B5`. This key matches itself after a shift of eight bits, so the overlap path of the transition table is exercised. A full key walks through all 16 states. The bench flips each of the eight stored bits in turn while a key is in progress, and also sends two-bit flips in the middle of a key. These cover correction, scrubbing and the fall to idle. Gaps in `in_valid` and near-miss keys that differ in one bit test that the prefix is held and that no false match is reported.

// File: rtl/key_fsm_pkg.sv
package key_fsm_pkg;
  localparam int IDX_W  = 4;
  localparam int WORD_W = 8;

  // Stored word layout: [7]=i3 [6]=i2 [5]=i1 [4]=c3 [3]=i0 [2]=c2 [1]=c1 [0]=overall parity
  function automatic logic [WORD_W-1:0] word_encode(input logic [IDX_W-1:0] d);
    logic [WORD_W-1:0] w;
    w[3] = d[0];
    w[5] = d[1];
    w[6] = d[2];
    w[7] = d[3];
    w[1] = d[0] ^ d[1] ^ d[3];
    w[2] = d[0] ^ d[2] ^ d[3];
    w[4] = d[1] ^ d[2] ^ d[3];
    w[0] = ^w[7:1];
    return w;
  endfunction

  // Transition entry: bits [3:0] next prefix length, bit 4 match
  function automatic logic [4:0] prefix_step(input int s, input int b, input int w,
                                             input logic [31:0] key);
    int best;
    int p;
    bit hit;
    bit ok;
    bit c;
    int lmax;
    if (s >= w) return 5'd0;
    hit  = (s == w - 1) && (key[0] == b[0]);
    lmax = (s + 1 > w - 1) ? w - 1 : s + 1;
    best = 0;
    for (int len = lmax; len >= 1; len--) begin
      if (best == 0) begin
        ok = 1'b1;
        for (int j = 0; j < len; j++) begin
          p = s + 1 - len + j;
          c = (p == s) ? b[0] : key[w-1-p];
          if (c != key[w-1-j]) ok = 1'b0;
        end
        if (ok) best = len;
      end
    end
    return {hit, 4'(best)};
  endfunction
endpackage

// File: rtl/state_word_encoder.sv
module state_word_encoder
  import key_fsm_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] word
);
  assign word = word_encode(idx);
endmodule

// File: rtl/state_word_decoder.sv
module state_word_decoder
  import key_fsm_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic [IDX_W-1:0]  idx,
  output logic              single_err,
  output logic              double_err,
  output logic              any_err
);
  logic [2:0] syn;
  logic       par;

  always_comb begin
    syn[0] = word[1] ^ word[3] ^ word[5] ^ word[7];
    syn[1] = word[2] ^ word[3] ^ word[6] ^ word[7];
    syn[2] = word[4] ^ word[5] ^ word[6] ^ word[7];
    par    = ^word;
    single_err = par;
    double_err = !par && (syn != 3'd0);
    any_err    = par || (syn != 3'd0);
    idx[0] = word[3] ^ (single_err && syn == 3'd3);
    idx[1] = word[5] ^ (single_err && syn == 3'd5);
    idx[2] = word[6] ^ (single_err && syn == 3'd6);
    idx[3] = word[7] ^ (single_err && syn == 3'd7);
  end
endmodule

// File: rtl/prefix_step_table.sv
module prefix_step_table
  import key_fsm_pkg::*;
#(
  parameter int              KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY  = 16'hB5B5
) (
  input  logic [IDX_W-1:0] cur,
  input  logic             bit_in,
  output logic [IDX_W-1:0] nxt,
  output logic             hit
);
  localparam int ENTRIES = 2 ** (IDX_W + 1);

  logic [IDX_W-1:0] nxt_tbl [ENTRIES];
  logic             hit_tbl [ENTRIES];

  for (genvar s = 0; s < 2 ** IDX_W; s++) begin : g_state
    for (genvar b = 0; b < 2; b++) begin : g_bit
      localparam logic [4:0] ENT = prefix_step(s, b, KEY_W, 32'(KEY));
      assign nxt_tbl[s*2+b] = ENT[3:0];
      assign hit_tbl[s*2+b] = ENT[4];
    end
  end

  assign nxt = nxt_tbl[{cur, bit_in}];
  assign hit = hit_tbl[{cur, bit_in}];
endmodule

// File: rtl/upset_tolerant_key_fsm.sv
module upset_tolerant_key_fsm
  import key_fsm_pkg::*;
#(
  parameter int              KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY  = 16'hB5B5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  input  logic [WORD_W-1:0] seu_flip,
  output logic              match_o,
  output logic              upset_o
);
  localparam logic [WORD_W-1:0] IDLE_WORD = word_encode(IDX_W'(0));

  logic [WORD_W-1:0] state_word;
  logic [WORD_W-1:0] next_word;
  logic [IDX_W-1:0]  cur_idx;
  logic [IDX_W-1:0]  step_idx;
  logic [IDX_W-1:0]  next_idx;
  logic              step_hit;
  logic              take_hit;
  logic              single_err;
  logic              double_err;
  logic              any_err;

  state_word_decoder u_dec (
    .word       (state_word),
    .idx        (cur_idx),
    .single_err (single_err),
    .double_err (double_err),
    .any_err    (any_err)
  );

  prefix_step_table #(.KEY_W(KEY_W), .KEY(KEY)) u_tbl (
    .cur    (cur_idx),
    .bit_in (in_bit),
    .nxt    (step_idx),
    .hit    (step_hit)
  );

  always_comb begin
    if (double_err) begin
      next_idx = '0;
      take_hit = 1'b0;
    end else if (in_valid) begin
      next_idx = step_idx;
      take_hit = step_hit;
    end else begin
      next_idx = cur_idx;
      take_hit = 1'b0;
    end
  end

  state_word_encoder u_enc (
    .idx  (next_idx),
    .word (next_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_word <= IDLE_WORD;
      match_o    <= 1'b0;
      upset_o    <= 1'b0;
    end else begin
      state_word <= next_word ^ seu_flip;
      match_o    <= take_hit;
      upset_o    <= any_err;
    end
  end

  assign in_ready = 1'b1;

  logic unused_single;
  assign unused_single = single_err;
endmodule

// File: rtl/key_fsm_checker.sv
module key_fsm_checker
  import key_fsm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] seu_flip,
  input logic              match_o,
  input logic              upset_o,
  input logic [WORD_W-1:0] stored_word
);
  logic [2:0] chk_syn;
  assign chk_syn = {stored_word[4] ^ stored_word[5] ^ stored_word[6] ^ stored_word[7],
                    stored_word[2] ^ stored_word[3] ^ stored_word[6] ^ stored_word[7],
                    stored_word[1] ^ stored_word[3] ^ stored_word[5] ^ stored_word[7]};

  assert_legal_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seu_flip == '0) |=> ((chk_syn == 3'd0) && !(^stored_word)));

  assert_single_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(seu_flip) == 1) |=> ##1 upset_o);

  assert_quiet_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seu_flip, 2) == '0) |-> !upset_o);

  assert_match_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> $past(in_valid));

  assert_double_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (($countones(seu_flip) == 2) ##1 (seu_flip == '0)) |=>
      (!match_o && stored_word == word_encode(IDX_W'(0))));
endmodule

bind upset_tolerant_key_fsm key_fsm_checker u_key_fsm_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .seu_flip    (seu_flip),
  .match_o     (match_o),
  .upset_o     (upset_o),
  .stored_word (state_word)
);

// File: tb/test_upset_tolerant_key_fsm.sv
`timescale 1ns/1ps
module test_upset_tolerant_key_fsm;
  localparam int         KW  = 16;
  localparam logic [15:0] KEY = 16'hB5B5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_bit = 1'b0;
  logic [7:0] seu_flip = 8'h00;
  logic       match_o;
  logic       upset_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  m;
    logic  u;
    string req;
  } item_t;
  item_t sb[$];

  // reference model state
  logic [15:0] hist = '0;
  int          cnt = 0;
  logic [7:0]  prev_flip = '0;

  always #2.5 clk = ~clk;

  upset_tolerant_key_fsm #(.KEY_W(KW), .KEY(KEY)) i_upset_tolerant_key_fsm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .seu_flip(seu_flip), .match_o(match_o), .upset_o(upset_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic step(input logic v, input logic b, input logic [7:0] flip, input string req);
    item_t it;
    @(negedge clk);
    in_valid = v;
    in_bit   = b;
    seu_flip = flip;
    it.u   = (prev_flip != 8'h00);
    it.req = req;
    if ($countones(prev_flip) == 2) begin
      hist = '0;
      cnt  = 0;
      it.m = 1'b0;
    end else if (v) begin
      hist = {hist[14:0], b};
      cnt++;
      it.m = (cnt >= KW) && (hist == KEY);
    end else begin
      it.m = 1'b0;
    end
    prev_flip = flip;
    sb.push_back(it);
  endtask

  task automatic feed(input logic [15:0] val, input int n, input string req);
    for (int i = n - 1; i >= 0; i--) step(1'b1, val[i], 8'h00, req);
  endtask

  // monitor: one scoreboard item per cycle
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        check(match_o === it.m, it.req, "match_o", int'(match_o), int'(it.m));
        check(upset_o === it.u, it.req, "upset_o", int'(upset_o), int'(it.u));
        check(in_ready === 1'b1, "R1", "in_ready", int'(in_ready), 1);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    // R10: flips held during reset must be ignored
    seu_flip = 8'hFF;
    repeat (4) @(negedge clk);
    seu_flip = 8'h00;
    rst_n = 1'b1;
    #1;
    check(match_o === 1'b0, "R1", "match_o after reset", int'(match_o), 0);
    check(upset_o === 1'b0, "R10", "upset_o after reset", int'(upset_o), 0);

    // R1, R2: key straight after reset
    feed(KEY, 16, "R1");
    step(1'b0, 1'b0, 8'h00, "R4");
    // R3: overlap by 8
    feed(KEY, 16, "R2");
    feed(KEY, 8, "R3");
    feed(16'h0000, 5, "R2");
    // near misses: every single-bit variant of the key
    for (int k = 0; k < 16; k++) begin
      feed(KEY ^ (16'h1 << k), 16, "R2");
      feed(16'h0000, 3, "R2");
    end
    // R4: gaps inside a key
    for (int i = 15; i >= 0; i--) begin
      step(1'b1, KEY[i], 8'h00, "R4");
      if (i % 3 == 0) begin
        step(1'b0, ~KEY[i], 8'h00, "R4");
        step(1'b0, 1'b1, 8'h00, "R4");
      end
    end
    feed(16'h0000, 4, "R4");
    // R6, R7: single flip of each stored bit mid-key
    for (int p = 0; p < 8; p++) begin
      for (int i = 15; i >= 0; i--)
        step(1'b1, KEY[i], (i == 9) ? (8'h01 << p) : 8'h00, "R6");
      feed(16'h0000, 2, "R7");
    end
    // R8: singles in different bits on consecutive edges
    for (int i = 15; i >= 0; i--)
      step(1'b1, KEY[i], (i == 7) ? 8'h08 : (i == 6) ? 8'h40 : (i == 5) ? 8'h01 : 8'h00, "R8");
    feed(16'h0000, 2, "R8");
    // R9: two-bit flip mid-key drops the prefix and the next bit
    for (int i = 15; i >= 6; i--) step(1'b1, KEY[i], (i == 6) ? 8'h12 : 8'h00, "R9");
    feed(KEY, 6, "R9");
    feed(KEY, 16, "R9");
    step(1'b0, 1'b0, 8'h81, "R9");
    step(1'b0, 1'b0, 8'h00, "R9");
    feed(KEY, 16, "R9");
    // mixed stream with planted keys and sparse single flips
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (n % 97 == 10) feed(KEY, 16, "R3");
      step(lfsr[3] | lfsr[7], lfsr[0],
           (n % 11 == 4) ? (8'h01 << lfsr[6:4]) : 8'h00, "R6");
    end
    step(1'b0, 1'b0, 8'h00, "R4");
    step(1'b0, 1'b0, 8'h00, "R4");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule